// File: doc/BRIEF.md
# Sync-Gated ADC Scan Sequencer

This block walks a scan of up to sixteen conversion slots over one or two converters. Each slot owns one bit of a scan-control word. A clear bit lets the slot's conversion request follow the previous slot's completion at once. A set bit holds the slot until a fresh, enabled sync edge arrives after that completion. The converters are seen only through a one-cycle request output, the slot index presented with it, and a one-cycle done input.

Three scan modes set the order in which bits are consumed.
- **Sequential:** a single walk over all slots.
- **Paired:** both converters are requested in the same cycle, and the walk advances only when both have reported done.
- **Split:** two independent walks run at once. Each converter takes an interleaved half of the control word.

Stop is a level. While it is high the walkers stay idle. Raising it during a scan ends the scan at the next slot boundary. When the first slot is gated, lowering stop arms the walker, and the first enabled sync edge starts the scan without a start pulse.

Each walker is a three-state machine:
- **IDLE**: parked at step 0.
- **HOLD**: waiting for a sync edge.
- **CONV**: a conversion is outstanding.

Its transitions are:
- IDLE→CONV: start with an ungated first slot, or sync on a gated first slot.
- IDLE→HOLD: start with a gated first slot.
- HOLD→CONV: an enabled sync edge.
- HOLD→IDLE: stop.
- CONV→CONV: done, with the next slot ungated.
- CONV→HOLD: done, with the next slot gated.
- CONV→IDLE: done on the last step (this raises complete), or done while stop is high.

Top module: `scan_sequencer`

## Requirements
- R1: After reset the control word is all zeros and every request and complete output is low, so a scan started without any write runs every slot ungated.
- R2: A slot whose control bit is 0 is requested after the previous slot's done, with no sync edge needed.
- R3: A slot whose control bit is 1 is requested only after a sync edge that is detected after the previous slot's done. An edge seen while a conversion is outstanding releases nothing.
- R4: With `mode` = 2'b00 (2'b11 behaves the same), converter 0 alone is requested for slots 0 through 15 in ascending order, and the scan uses bits 0 to 15.
- R5: With `mode` = 2'b01, both request bits assert in the same cycle for slots 0 through 7, using bits 0 to 7. A step ends only when both converters have reported done. The end of the scan is flagged on `scan_done[0]` only.
- R6: With `mode` = 2'b10, the two converters walk independently. Converter 0 takes slots 0–3 and then 8–11. Converter 1 takes slots 4–7 and then 12–15. Each flags its own complete bit.
- R7: When the first slot of a walk is gated and stop is low, a sync edge starts the scan from idle without a start pulse.
- R8: While `sync_en` is low, sync edges are ignored, and a gated slot waits until stop is raised.
- R9: Stop ends a scan at the next slot boundary, either on the outstanding done or at once in HOLD. No further request follows, no complete is flagged, and the next start begins at slot 0.
- R10: `sync_in` passes through a two-flop synchroniser and is rising-edge detected. A pulse held high for several cycles counts once, and one edge releases at most one gated slot per converter.
- R11: A complete bit is a one-cycle pulse, raised when the last slot of that walk reports done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the scan-control word |
| cfg_wdata | input | NSLOT | New scan-control word (bit n gates slot n) |
| mode | input | 2 | 00 sequential, 01 paired, 10 split, 11 as sequential |
| start | input | 1 | One-cycle scan start |
| stop | input | 1 | Level; high holds idle and ends a running scan at a boundary |
| sync_in | input | 1 | Asynchronous sync input, rising edge used |
| sync_en | input | 1 | High lets sync edges release gated slots |
| conv_done | input | 2 | One-cycle done per converter |
| conv_req | output | 2 | One-cycle conversion request per converter |
| slot_a | output | SLOT_W | Slot index for converter 0, valid with its request |
| slot_b | output | SLOT_W | Slot index for converter 1, valid with its request |
| scan_done | output | 2 | One-cycle scan-complete pulse per converter |

## Verification
The bench builds the block with the default of sixteen slots. With that width, the full sequential walk, the eight-step paired walk and both interleaved four-plus-four split walks can all be observed, including the jump across the middle of the word. The converter models answer with different latencies per converter. This lets the paired walk's wait for both dones and the independence of the split walks show up in the request order and timing.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        MODE_SEQ   = 2'b00,
        MODE_PAIR  = 2'b01,
        MODE_SPLIT = 2'b10,
        MODE_RSV   = 2'b11
    } scan_mode_e;

    typedef enum logic [1:0] {
        WK_IDLE = 2'b00,
        WK_HOLD = 2'b01,
        WK_CONV = 2'b10
    } walk_state_e;
endpackage

// File: rtl/scan_sync_edge.sv
module scan_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    output logic pulse
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pulse = sync_q & ~prev_q & en;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R10
endmodule

// File: rtl/scan_walker.sv
module scan_walker
    import scan_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int SLOT_W = $clog2(NSLOT),
    parameter int CID    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  scan_mode_e        mode,
    input  logic              start,
    input  logic              stop,
    input  logic              sync_go,
    input  logic [NSLOT-1:0]  sc,
    input  logic              done_in,
    output logic              req,
    output logic [SLOT_W-1:0] slot,
    output logic              cplt
);
    localparam int HALF  = NSLOT / 2;
    localparam int QUART = NSLOT / 4;

    walk_state_e       st_q, st_d;
    logic [SLOT_W-1:0] step_q, step_d, step_nx;
    logic              req_q, req_d, cplt_q, cplt_d, last;

    function automatic logic [SLOT_W-1:0] slot_of(input logic [SLOT_W-1:0] s,
                                                 input scan_mode_e m);
        int v;
        if (m == MODE_SPLIT)
            v = (int'(s) / QUART) * HALF + CID * QUART + (int'(s) % QUART);
        else
            v = int'(s);
        return SLOT_W'(v);
    endfunction

    assign step_nx = step_q + 1'b1;
    assign last    = (mode == MODE_PAIR || mode == MODE_SPLIT) ?
                     (step_q == SLOT_W'(HALF - 1)) : (step_q == SLOT_W'(NSLOT - 1));

    always_comb begin
        st_d   = st_q;
        step_d = step_q;
        req_d  = 1'b0;
        cplt_d = 1'b0;
        unique case (st_q)
            WK_IDLE: begin
                step_d = '0;
                if (active && !stop) begin
                    if (start) begin
                        if (sc[slot_of('0, mode)]) st_d = WK_HOLD;
                        else begin
                            st_d  = WK_CONV;
                            req_d = 1'b1;
                        end
                    end else if (sc[slot_of('0, mode)] && sync_go) begin
                        st_d  = WK_CONV;
                        req_d = 1'b1;
                    end
                end
            end
            WK_HOLD: begin
                if (stop) begin
                    st_d   = WK_IDLE;
                    step_d = '0;
                end else if (sync_go) begin
                    st_d  = WK_CONV;
                    req_d = 1'b1;
                end
            end
            WK_CONV: begin
                if (done_in) begin
                    if (last) begin
                        st_d   = WK_IDLE;
                        step_d = '0;
                        cplt_d = 1'b1;
                    end else if (stop) begin
                        st_d   = WK_IDLE;
                        step_d = '0;
                    end else begin
                        step_d = step_nx;
                        if (sc[slot_of(step_nx, mode)]) st_d = WK_HOLD;
                        else begin
                            st_d  = WK_CONV;
                            req_d = 1'b1;
                        end
                    end
                end
            end
            default: st_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WK_IDLE;
            step_q <= '0;
            req_q  <= 1'b0;
            cplt_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            req_q  <= req_d;
            cplt_q <= cplt_d;
        end
    end

    assign req  = req_q;
    assign cplt = cplt_q;
    assign slot = slot_of(step_q, mode);

    AST_GATED_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && sc[slot] && $stable(sc)) |-> $past(sync_go)); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_CONV && !done_in) |=> !req_q); // R2
    AST_HOLD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_HOLD && stop) |=> (st_q == WK_IDLE && !req_q)); // R9
    AST_CPLT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cplt_q |=> !cplt_q); // R11
    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && (mode == MODE_PAIR || mode == MODE_SPLIT)) |-> (int'(step_q) < HALF)); // R5
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [NSLOT-1:0]  cfg_wdata,
    input  logic [1:0]        mode,
    input  logic              start,
    input  logic              stop,
    input  logic              sync_in,
    input  logic              sync_en,
    input  logic [1:0]        conv_done,
    output logic [1:0]        conv_req,
    output logic [SLOT_W-1:0] slot_a,
    output logic [SLOT_W-1:0] slot_b,
    output logic [1:0]        scan_done
);
    localparam int NCONV = 2;

    scan_mode_e        mode_e;
    logic [NSLOT-1:0]  sc_q;
    logic              sync_go, pair_join;
    logic [NCONV-1:0]  got_q, w_req, w_cplt;
    logic [SLOT_W-1:0] w_slot [NCONV];

    assign mode_e = scan_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (!rst_n)      sc_q <= '0;
        else if (cfg_we) sc_q <= cfg_wdata;
    end

    scan_sync_edge u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .en    (sync_en),
        .pulse (sync_go)
    );

    assign pair_join = &(got_q | conv_done);

    always_ff @(posedge clk) begin
        if (!rst_n)                                  got_q <= '0;
        else if (mode_e != MODE_PAIR || pair_join)   got_q <= '0;
        else                                         got_q <= got_q | conv_done;
    end

    for (genvar c = 0; c < NCONV; c++) begin : g_walk
        logic act, dn;
        if (c == 0) begin : g_lead
            assign act = 1'b1;
            assign dn  = (mode_e == MODE_PAIR) ? pair_join : conv_done[0];
        end else begin : g_follow
            assign act = (mode_e == MODE_SPLIT);
            assign dn  = conv_done[c];
        end
        scan_walker #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .CID(c)) u_walk (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (act),
            .mode    (mode_e),
            .start   (start),
            .stop    (stop),
            .sync_go (sync_go),
            .sc      (sc_q),
            .done_in (dn),
            .req     (w_req[c]),
            .slot    (w_slot[c]),
            .cplt    (w_cplt[c])
        );
    end

    assign conv_req  = {(mode_e == MODE_PAIR) ? w_req[0] : w_req[1], w_req[0]};
    assign slot_a    = w_slot[0];
    assign slot_b    = (mode_e == MODE_PAIR) ? w_slot[0] : w_slot[1];
    assign scan_done = w_cplt;

    AST_SEQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_SEQ && $stable(mode_e)) |-> !conv_req[1]); // R4
endmodule

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;
    localparam int NSLOT  = 16;
    localparam int SLOT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [NSLOT-1:0] cfg_wdata = '0;
    logic [1:0] mode = 2'b00;
    logic start = 1'b0, stop = 1'b1, sync_in = 1'b0, sync_en = 1'b1;
    logic [1:0] conv_done = 2'b00;
    logic [1:0] conv_req, scan_done;
    logic [SLOT_W-1:0] slot_a, slot_b;

    int nchk = 0, nfail = 0;
    int rc[2] = '{0, 0};
    int dc[2] = '{0, 0};
    int lat[2] = '{3, 3};
    int cnt[2] = '{0, 0};
    logic [1:0] prev_sd = 2'b00;
    int qa[$];
    int qb[$];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scan_sequencer #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) i_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mode(mode), .start(start), .stop(stop), .sync_in(sync_in),
        .sync_en(sync_en), .conv_done(conv_done), .conv_req(conv_req),
        .slot_a(slot_a), .slot_b(slot_b), .scan_done(scan_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor and converter responders
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_req[0]) begin
                rc[0]++;
                if (qa.size() == 0) chk(1'b0, "R4 unexpected request conv0", int'(slot_a), -1);
                else begin
                    int e;
                    e = qa.pop_front();
                    chk(int'(slot_a) == e, "R4 slot order conv0", int'(slot_a), e);
                end
            end
            if (conv_req[1]) begin
                rc[1]++;
                if (qb.size() == 0) chk(1'b0, "R6 unexpected request conv1", int'(slot_b), -1);
                else begin
                    int e;
                    e = qb.pop_front();
                    chk(int'(slot_b) == e, "R6 slot order conv1", int'(slot_b), e);
                end
            end
            if (mode == 2'b01 && conv_req[0] != conv_req[1])
                chk(1'b0, "R5 paired requests not together", int'(conv_req), 3);
            for (int c = 0; c < 2; c++) begin
                if (scan_done[c]) begin
                    dc[c]++;
                    chk(!prev_sd[c], "R11 complete wider than one cycle", 1, 0);
                end
                conv_done[c] = 1'b0;
                if (cnt[c] > 0) begin
                    cnt[c]--;
                    if (cnt[c] == 0) conv_done[c] = 1'b1;
                end
                if (conv_req[c]) cnt[c] = lat[c];
            end
            prev_sd = scan_done;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_sc(input logic [NSLOT-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic sync_pulse();
        @(negedge clk); sync_in = 1'b1;
        cyc(3);
        sync_in = 1'b0;
    endtask

    task automatic push_a(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) qa.push_back(i);
    endtask

    task automatic push_b(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) qb.push_back(i);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base, basea, baseb;
        cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_req == 2'b00, "R1 reset request low", int'(conv_req), 0);
        chk(scan_done == 2'b00, "R1 reset complete low", int'(scan_done), 0);

        // R1 R2 R4 R11: default word, sequential walk, no sync ever
        stop = 1'b0;
        push_a(0, 15);
        go();
        cyc(120);
        chk(rc[0] == 16, "R2 ungated walk count", rc[0], 16);
        chk(dc[0] == 1, "R11 sequential complete", dc[0], 1);
        chk(qa.size() == 0, "R1 all default slots seen", qa.size(), 0);

        // R3: bit1 gated; edge during conversion ignored
        wr_sc(16'h0002);
        lat[0] = 30;
        push_a(0, 0);
        base = rc[0];
        go();
        cyc(5);
        sync_pulse();
        cyc(40);
        chk(rc[0] - base == 1, "R3 edge during conversion ignored", rc[0] - base, 1);
        lat[0] = 3;
        push_a(1, 15);
        sync_pulse();
        cyc(120);
        chk(rc[0] - base == 16, "R3 released after edge", rc[0] - base, 16);
        chk(dc[0] == 2, "R11 second complete", dc[0], 2);

        // R7: gated first slot, start-free arming by stop low
        stop = 1'b1;
        wr_sc(16'h0001);
        cyc(3);
        base = rc[0];
        stop = 1'b0;
        cyc(12);
        chk(rc[0] == base, "R7 armed walker waits for sync", rc[0] - base, 0);
        push_a(0, 15);
        sync_pulse();
        cyc(120);
        chk(rc[0] - base == 16, "R7 sync-started scan", rc[0] - base, 16);
        chk(dc[0] == 3, "R7 sync-started complete", dc[0], 3);
        stop = 1'b1;

        // R8 R9: masked sync, stop from HOLD, restart at slot 0
        wr_sc(16'h0004);
        sync_en = 1'b0;
        stop = 1'b0;
        base = rc[0];
        push_a(0, 1);
        go();
        cyc(30);
        sync_pulse();
        cyc(20);
        chk(rc[0] - base == 2, "R8 masked sync leaves slot held", rc[0] - base, 2);
        stop = 1'b1;
        cyc(3);
        stop = 1'b0;
        sync_en = 1'b1;
        push_a(0, 1);
        go();
        cyc(30);
        chk(rc[0] - base == 4, "R9 restart from slot 0", rc[0] - base, 4);
        chk(dc[0] == 3, "R9 no complete after stop", dc[0], 3);
        push_a(2, 15);
        sync_pulse();
        cyc(120);
        chk(dc[0] == 4, "R8 scan finishes once enabled", dc[0], 4);

        // R9: stop during an outstanding conversion
        wr_sc(16'h0000);
        lat[0] = 20;
        base = rc[0];
        push_a(0, 0);
        go();
        cyc(5);
        stop = 1'b1;
        cyc(40);
        chk(rc[0] - base == 1, "R9 no request after boundary", rc[0] - base, 1);
        chk(dc[0] == 4, "R9 aborted scan not complete", dc[0], 4);
        stop = 1'b0;
        lat[0] = 3;
        push_a(0, 15);
        go();
        cyc(120);
        chk(dc[0] == 5, "R9 full scan after abort", dc[0], 5);

        // R5: paired mode, gated at bit4, unequal latencies
        mode = 2'b01;
        wr_sc(16'h0010);
        lat[0] = 2;
        lat[1] = 6;
        basea = rc[0];
        baseb = rc[1];
        push_a(0, 3);
        push_b(0, 3);
        go();
        cyc(60);
        chk(rc[0] - basea == 4, "R5 paired held at gated step", rc[0] - basea, 4);
        chk(rc[1] - baseb == 4, "R5 paired partner count", rc[1] - baseb, 4);
        push_a(4, 7);
        push_b(4, 7);
        sync_pulse();
        cyc(80);
        chk(rc[0] - basea == 8, "R5 paired eight steps", rc[0] - basea, 8);
        chk(dc[0] == 6, "R5 paired complete on bit0", dc[0], 6);
        chk(dc[1] == 0, "R5 no complete on bit1", dc[1], 0);

        // R6 R10: split mode; conv1 gated at slots 4,5; conv0 gated at slot 8
        mode = 2'b10;
        wr_sc(16'h0130);
        lat[0] = 3;
        lat[1] = 4;
        basea = rc[0];
        baseb = rc[1];
        push_a(0, 3);
        go();
        cyc(60);
        chk(rc[0] - basea == 4, "R6 conv0 first quarter", rc[0] - basea, 4);
        chk(rc[1] - baseb == 0, "R6 conv1 held at slot 4", rc[1] - baseb, 0);
        push_a(8, 11);
        push_b(4, 4);
        sync_pulse();
        cyc(40);
        chk(rc[1] - baseb == 1, "R10 one edge releases one slot", rc[1] - baseb, 1);
        chk(rc[0] - basea == 8, "R6 conv0 second quarter", rc[0] - basea, 8);
        chk(dc[0] == 7, "R6 conv0 own complete", dc[0], 7);
        push_b(5, 7);
        push_b(12, 15);
        sync_pulse();
        cyc(80);
        chk(rc[1] - baseb == 8, "R6 conv1 walk length", rc[1] - baseb, 8);
        chk(dc[1] == 1, "R6 conv1 own complete", dc[1], 1);
        chk(qa.size() == 0 && qb.size() == 0, "R6 scoreboard drained",
            qa.size() + qb.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule